// File: doc/BRIEF.md
# Converter Output Demultiplexer and Formatter

This block sits behind a pair of 12-bit sample converters, I and Q, and packs their results onto four 12-bit output buses: two primary buses (`bus_di`, `bus_dq`) and two delayed buses (`bus_did`, `bus_dqd`). It also produces the matching output data clocks (`dclk_i`, `dclk_q`). Static mode inputs choose the layout:

- **Channel mode.** The channels either run independently, or interleave one analog input in dual-edge mode. In dual-edge mode one converter takes the input on the rising sampling edge and the other on the falling edge.
- **Bus mode.** Output is either at the full slot rate on one bus per stream, or demultiplexed. Demultiplexed output runs at half the rate on twice as many buses.
- **Clocking.** The output clock is either single or double data rate, with a selectable data-to-clock phase.

A 16-bit configuration word can take over the dual-edge enable, the input selection for dual-edge mode and the phase select. Bus mode and clocking rate always stay on their pins.

All timing is on one internal clock `clk`. Each sample slot lasts two ticks. Tick 0 is the first rising edge at which `rst_n` is sampled high, and slot k is taken at tick 2k.

A formatter FSM with two states controls when output starts:

- **FILL** is entered by reset. The buses and clocks stay at zero in this state.
- **FILL→RUN** (transition *first_word*) happens at the first word load.
- **RUN** stays until the next reset (transition *hold_run*).

The mode is captured into a latch while reset is asserted, so a mode change takes effect only through a reset.

Top module: `adc_demux_fmt`

## Requirements
- R1: A slot is taken at every even tick. A word holds P slots, where P=1 when `pin_split`=0 and P=2 when `pin_split`=1. Word j is loaded onto the buses at tick 2P·j+2P−2, and the new values are visible after that edge.
- R2: While `rst_n` is low, and after reset until the first word load, all four buses and both data clocks are 0.
- R3: Independent, non-demultiplexed: `bus_di` carries the I sample of the word's slot and `bus_dq` carries the Q sample. `bus_did` and `bus_dqd` are 0.
- R4: Independent, demultiplexed: `bus_did`/`bus_dqd` carry the I/Q samples of the earlier slot. `bus_di`/`bus_dq` carry the I/Q samples of the later slot.
- R5: Dual-edge, non-demultiplexed: `bus_di` carries the rising-edge sample, which is earlier in time, and `bus_dq` carries the falling-edge sample. The delayed buses are 0.
- R6: Dual-edge, demultiplexed: four consecutive combined samples appear in time order on `bus_did`, `bus_dqd`, `bus_di`, `bus_dq`.
- R7: With Q-input selection active in dual-edge mode, the Q converter (`samp_q`) is the rising-edge converter. Otherwise the I converter (`samp_i`) is the rising-edge converter.
- R8: Double data rate (`pin_ddr`=1), selected by the phase bit:
  - phase 0: the data clocks toggle at every word load.
  - phase 1: the data clocks toggle P ticks after each load, midway between loads.
- R9: Single data rate (`pin_ddr`=0), selected by the phase bit:
  - phase 1 (rising capture): the clocks go to 0 at each load and to 1 P ticks later.
  - phase 0 (falling capture): the clocks go to 1 at each load and to 0 P ticks later.
- R10: Source of the mode fields, selected by `cfg_sel`:
  - `cfg_sel`=1: dual-edge comes from config bit 7, Q-input select from bit 6 and phase from bit 14. `pin_dual_edge` and `pin_phase` are ignored.
  - `cfg_sel`=0: the pins are used and Q-input select is 0.
  - In both cases, `pin_split` and `pin_ddr` always act.
- R11: Mode inputs and `cfg_sel` changing while `rst_n` is high have no effect until the next reset.
- R12: Buses hold their value between word loads, and `dclk_i` equals `dclk_q` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, two ticks per sample slot |
| rst_n | input | 1 | Synchronous reset, active low; the mode is latched while low |
| pin_dual_edge | input | 1 | 1 = dual-edge interleaved, 0 = independent channels |
| pin_split | input | 1 | 1 = demultiplexed (two slots per word), 0 = one slot per word |
| pin_ddr | input | 1 | 1 = double data rate clock, 0 = single data rate |
| pin_phase | input | 1 | Phase select (DDR: 0°/90°; SDR: falling/rising capture) |
| cfg_sel | input | 1 | 1 = config word drives dual-edge, Q-select and phase |
| cfg_we | input | 1 | Write strobe for the config word |
| cfg_wdata | input | 16 | Config word: bit 7 dual-edge, bit 6 Q-input select, bit 14 phase |
| samp_i | input | 12 | I converter result for the current slot |
| samp_q | input | 12 | Q converter result for the current slot |
| bus_di | output | 12 | Primary I-side bus |
| bus_did | output | 12 | Delayed I-side bus |
| bus_dq | output | 12 | Primary Q-side bus |
| bus_dqd | output | 12 | Delayed Q-side bus |
| dclk_i | output | 1 | Data clock for the I-side buses |
| dclk_q | output | 1 | Data clock for the Q-side buses |

## Verification
The bench counts rising edges from reset release and changes sample inputs only on falling edges. Slot k is therefore present at tick 2k. Every output is read at the falling edge after each rising edge, and compared against the value computed for that tick number:

- **Buses.** Zero before tick 2P−2. The ramp word j from tick 2P·j+2P−2 onward.
- **Data clocks.** Level set from the offset of the tick within the word (load offset 0, midpoint offset P) and the count of loads or midpoints passed.

The samples are ramps with distinct I, Q and interleaved ranges, so a missing, repeated or swapped sample shows up as a mismatch on the tick it should have appeared.

// File: rtl/adc_fmt_pkg.sv
`timescale 1ns/1ps
package adc_fmt_pkg;

    // Resolved formatter mode, frozen while the formatter runs
    typedef struct packed {
        logic dual;   // dual-edge interleave
        logic qsel;   // Q converter is the rising-edge converter
        logic split;  // two slots per output word
        logic ddr;    // double data rate output clock
        logic phase;  // data-to-clock phase select
    } fmt_mode_t;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fmt_state_t;

endpackage

// File: rtl/adc_fmt_mode.sv
`timescale 1ns/1ps
module adc_fmt_mode
    import adc_fmt_pkg::*;
#(
    parameter int CFG_W     = 16,
    parameter int BIT_DUAL  = 7,
    parameter int BIT_QSEL  = 6,
    parameter int BIT_PHASE = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_dual_edge,
    input  logic             pin_split,
    input  logic             pin_ddr,
    input  logic             pin_phase,
    input  logic             cfg_sel,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output fmt_mode_t        mode_o
);

    // Only three fields of the config word carry meaning
    logic       reg_dual;
    logic       reg_qsel;
    logic       reg_phase;
    logic       cfg_unused;
    fmt_mode_t  mode_next;
    fmt_mode_t  mode_q;

    assign cfg_unused = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (cfg_we) begin
            reg_dual  <= cfg_wdata[BIT_DUAL];
            reg_qsel  <= cfg_wdata[BIT_QSEL];
            reg_phase <= cfg_wdata[BIT_PHASE];
        end
    end

    always_comb begin
        mode_next.split = pin_split;
        mode_next.ddr   = pin_ddr;
        if (cfg_sel) begin
            mode_next.dual  = reg_dual;
            mode_next.qsel  = reg_qsel;
            mode_next.phase = reg_phase;
        end else begin
            mode_next.dual  = pin_dual_edge;
            mode_next.qsel  = 1'b0;
            mode_next.phase = pin_phase;
        end
    end

    // Mode is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_next;
        end
    end

    assign mode_o = mode_q;

    // R11: mode frozen while running
    assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

endmodule

// File: rtl/adc_fmt_pack.sv
`timescale 1ns/1ps
module adc_fmt_pack
    import adc_fmt_pkg::*;
#(
    parameter int SAMP_W         = 12,
    parameter int TICKS_PER_SLOT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split,
    input  logic              swap,
    input  logic [SAMP_W-1:0] samp_i,
    input  logic [SAMP_W-1:0] samp_q,
    output logic [SAMP_W-1:0] bus_di,
    output logic [SAMP_W-1:0] bus_did,
    output logic [SAMP_W-1:0] bus_dq,
    output logic [SAMP_W-1:0] bus_dqd,
    output logic              word_load,
    output logic              word_mid
);

    localparam int SLOTS_SPLIT = 2;
    localparam int WLEN_ND     = TICKS_PER_SLOT;
    localparam int WLEN_DM     = TICKS_PER_SLOT * SLOTS_SPLIT;
    localparam int CW          = $clog2(WLEN_DM) + 1;
    localparam int LOAD_ND     = WLEN_ND - TICKS_PER_SLOT;
    localparam int LOAD_DM     = WLEN_DM - TICKS_PER_SLOT;
    localparam int MID_ND      = (LOAD_ND + WLEN_ND / 2) % WLEN_ND;
    localparam int MID_DM      = (LOAD_DM + WLEN_DM / 2) % WLEN_DM;

    logic [CW-1:0]     tcnt;
    logic [CW-1:0]     wlen_m1;
    logic [CW-1:0]     load_at;
    logic [CW-1:0]     mid_at;
    logic [SAMP_W-1:0] rise_s;
    logic [SAMP_W-1:0] fall_s;
    logic [SAMP_W-1:0] hold_rise;
    logic [SAMP_W-1:0] hold_fall;
    fmt_state_t        state_q;
    fmt_state_t        state_d;

    always_comb begin
        wlen_m1 = split ? CW'(WLEN_DM - 1) : CW'(WLEN_ND - 1);
        load_at = split ? CW'(LOAD_DM)     : CW'(LOAD_ND);
        mid_at  = split ? CW'(MID_DM)      : CW'(MID_ND);
    end

    // Tick position inside the current output word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (tcnt == wlen_m1) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + CW'(1);
        end
    end

    // Earlier-in-time converter first
    assign rise_s = swap ? samp_q : samp_i;
    assign fall_s = swap ? samp_i : samp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_rise <= '0;
            hold_fall <= '0;
        end else if (tcnt == '0) begin
            hold_rise <= rise_s;
            hold_fall <= fall_s;
        end
    end

    assign word_load = (tcnt == load_at);
    assign word_mid  = (tcnt == mid_at) && (state_q == ST_RUN);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (word_load) state_d = ST_RUN;   // first_word
            ST_RUN:  state_d = ST_RUN;                   // hold_run
            default: state_d = ST_FILL;
        endcase
    end

    // Output buses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_di  <= '0;
            bus_did <= '0;
            bus_dq  <= '0;
            bus_dqd <= '0;
        end else if (word_load) begin
            bus_di <= rise_s;
            bus_dq <= fall_s;
            if (split) begin
                bus_did <= hold_rise;
                bus_dqd <= hold_fall;
            end else begin
                bus_did <= '0;
                bus_dqd <= '0;
            end
        end
    end

    // R2: quiet until the first word
    assert_fill_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> ({bus_di, bus_did, bus_dq, bus_dqd} == '0));

    // R3: spare buses unused with one slot per word
    assert_spare_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !split |-> (bus_did == '0 && bus_dqd == '0));

    // R12: buses move only on word loads
    assert_hold_between_words_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !word_load |=> $stable({bus_di, bus_did, bus_dq, bus_dqd}));

endmodule

// File: rtl/adc_fmt_clkgen.sv
`timescale 1ns/1ps
module adc_fmt_clkgen (
    input  logic clk,
    input  logic rst_n,
    input  logic ddr,
    input  logic phase,
    input  logic word_load,
    input  logic word_mid,
    output logic dclk_i,
    output logic dclk_q
);

    logic dclk_r;
    logic dclk_n;

    always_comb begin
        dclk_n = dclk_r;
        unique case ({ddr, phase})
            2'b10: if (word_load) dclk_n = ~dclk_r;        // DDR, data on edge
            2'b11: if (word_mid)  dclk_n = ~dclk_r;        // DDR, data mid-bit
            2'b01: begin                                   // SDR, rising capture
                if (word_load)     dclk_n = 1'b0;
                else if (word_mid) dclk_n = 1'b1;
            end
            2'b00: begin                                   // SDR, falling capture
                if (word_load)     dclk_n = 1'b1;
                else if (word_mid) dclk_n = 1'b0;
            end
            default: dclk_n = dclk_r;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dclk_r <= 1'b0;
        end else begin
            dclk_r <= dclk_n;
        end
    end

    assign dclk_i = dclk_r;
    assign dclk_q = dclk_r;

    // R8: one transition per word load at 0 degrees
    assert_ddr_edge_per_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ddr && !phase && word_load) |=> (dclk_r != $past(dclk_r)));

    // R9: SDR level after load opposes the capture edge
    assert_sdr_launch_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr && word_load) |=> (dclk_r == !$past(phase)));

endmodule

// File: rtl/adc_demux_fmt.sv
`timescale 1ns/1ps
module adc_demux_fmt
    import adc_fmt_pkg::*;
#(
    parameter int SAMP_W         = 12,
    parameter int CFG_W          = 16,
    parameter int TICKS_PER_SLOT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_dual_edge,
    input  logic              pin_split,
    input  logic              pin_ddr,
    input  logic              pin_phase,
    input  logic              cfg_sel,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [SAMP_W-1:0] samp_i,
    input  logic [SAMP_W-1:0] samp_q,
    output logic [SAMP_W-1:0] bus_di,
    output logic [SAMP_W-1:0] bus_did,
    output logic [SAMP_W-1:0] bus_dq,
    output logic [SAMP_W-1:0] bus_dqd,
    output logic              dclk_i,
    output logic              dclk_q
);

    fmt_mode_t mode;
    logic      word_load;
    logic      word_mid;
    logic      swap;

    adc_fmt_mode #(
        .CFG_W (CFG_W)
    ) mode_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_dual_edge (pin_dual_edge),
        .pin_split     (pin_split),
        .pin_ddr       (pin_ddr),
        .pin_phase     (pin_phase),
        .cfg_sel       (cfg_sel),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .mode_o        (mode)
    );

    assign swap = mode.dual & mode.qsel;

    adc_fmt_pack #(
        .SAMP_W         (SAMP_W),
        .TICKS_PER_SLOT (TICKS_PER_SLOT)
    ) pack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .split     (mode.split),
        .swap      (swap),
        .samp_i    (samp_i),
        .samp_q    (samp_q),
        .bus_di    (bus_di),
        .bus_did   (bus_did),
        .bus_dq    (bus_dq),
        .bus_dqd   (bus_dqd),
        .word_load (word_load),
        .word_mid  (word_mid)
    );

    adc_fmt_clkgen clkgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ddr       (mode.ddr),
        .phase     (mode.phase),
        .word_load (word_load),
        .word_mid  (word_mid),
        .dclk_i    (dclk_i),
        .dclk_q    (dclk_q)
    );

endmodule

// File: tb/adc_demux_fmt_tb_top.sv
`timescale 1ns/1ps
module adc_demux_fmt_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_dual_edge = 1'b0;
    logic        pin_split = 1'b0;
    logic        pin_ddr = 1'b0;
    logic        pin_phase = 1'b0;
    logic        cfg_sel = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [11:0] samp_i = '0;
    logic [11:0] samp_q = '0;
    logic [11:0] bus_di, bus_did, bus_dq, bus_dqd;
    logic        dclk_i, dclk_q;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    adc_demux_fmt dut_i (
        .clk(clk), .rst_n(rst_n),
        .pin_dual_edge(pin_dual_edge), .pin_split(pin_split),
        .pin_ddr(pin_ddr), .pin_phase(pin_phase),
        .cfg_sel(cfg_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .samp_i(samp_i), .samp_q(samp_q),
        .bus_di(bus_di), .bus_did(bus_did), .bus_dq(bus_dq), .bus_dqd(bus_dqd),
        .dclk_i(dclk_i), .dclk_q(dclk_q)
    );

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] ri(input int k); return 12'(32'h100 + k); endfunction
    function automatic logic [11:0] rq(input int k); return 12'(32'h800 + k); endfunction
    function automatic logic [11:0] rc(input int m); return 12'(32'h300 + m); endfunction

    // Expected {di, did, dq, dqd} for word j
    function automatic logic [47:0] exp_bus(input bit d, input bit s, input int j);
        if (!d && !s) return {ri(j), 12'h0, rq(j), 12'h0};
        if (!d &&  s) return {ri(2*j+1), ri(2*j), rq(2*j+1), rq(2*j)};
        if ( d && !s) return {rc(2*j), 12'h0, rc(2*j+1), 12'h0};
        return {rc(4*j+2), rc(4*j), rc(4*j+3), rc(4*j+1)};
    endfunction

    function automatic logic exp_dclk(input bit s, input bit ddr, input bit ph, input int n);
        int p, w, e0, d, o;
        p = s ? 2 : 1;
        w = 2 * p;
        e0 = w - 2;
        if (n < e0) return 1'b0;
        d = n - e0;
        o = d % w;
        if (ddr && !ph) return 1'((d / w + 1) % 2);
        if (ddr && ph)  return 1'((d / w + ((o >= p) ? 1 : 0)) % 2);
        if (!ddr && ph) return (o >= p);
        return (o < p);
    endfunction

    task automatic setup(input bit d, input bit s, input bit ddr, input bit ph,
                         input bit sel, input logic [15:0] cw, input bit wr);
        @(negedge clk);
        rst_n = 1'b0;
        pin_dual_edge = d;
        pin_split = s;
        pin_ddr = ddr;
        pin_phase = ph;
        cfg_sel = sel;
        if (wr) begin
            cfg_wdata = cw;
            cfg_we = 1'b1;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R2", {bus_di, bus_did, bus_dq, bus_dqd}, 48'h0);
        chk("R2", {46'h0, dclk_i, dclk_q}, 48'h0);
        rst_n = 1'b1;
    endtask

    // Drive the ramp and check every tick; d/q/s/ddr/ph give the expected mode
    task automatic run_stream(input bit d, input bit q, input bit s, input bit ddr, input bit ph,
                              input string btag, input string ctag, input int nt, input bit flip);
        int p, w, e0;
        p = s ? 2 : 1;
        w = 2 * p;
        e0 = w - 2;
        for (int n = 0; n < nt; n++) begin
            int k;
            string t;
            logic [47:0] eb;
            k = n / 2;
            if (d) begin
                if (q) begin samp_q = rc(2*k); samp_i = rc(2*k+1); end
                else   begin samp_i = rc(2*k); samp_q = rc(2*k+1); end
            end else begin
                samp_i = ri(k);
                samp_q = rq(k);
            end
            if (flip && n == 8) begin
                pin_dual_edge = ~pin_dual_edge;
                pin_split = ~pin_split;
                pin_ddr = ~pin_ddr;
                pin_phase = ~pin_phase;
                cfg_sel = ~cfg_sel;
            end
            @(posedge clk);
            @(negedge clk);
            if (n < e0)                t = "R2";
            else if ((n - e0) % w != 0) t = "R12";
            else if (n == e0)           t = "R1";
            else                        t = btag;
            eb = (n < e0) ? 48'h0 : exp_bus(d, s, (n - e0) / w);
            chk(t, {bus_di, bus_did, bus_dq, bus_dqd}, eb);
            chk(ctag, {47'h0, dclk_i}, {47'h0, exp_dclk(s, ddr, ph, n)});
            chk("R12", {47'h0, dclk_q}, {47'h0, dclk_i});
        end
    endtask

    task automatic t_indep_full();      // R3, R8 at 0 degrees
        setup(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0);
        run_stream(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3", "R8", 20, 1'b0);
    endtask

    task automatic t_indep_split();     // R4, R8 at 90 degrees
        setup(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0);
        run_stream(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R4", "R8", 26, 1'b0);
    endtask

    task automatic t_cfg_qsel();        // R7, R10: bits 7, 6, 14 set; pins say otherwise
        setup(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h40C0, 1'b1);
        run_stream(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R7", "R10", 26, 1'b0);
    endtask

    task automatic t_dual_full();       // R5, R9 rising; stale Q-select bit must not act
        setup(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0);
        run_stream(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5", "R9", 20, 1'b0);
    endtask

    task automatic t_dual_split();      // R6, R9 falling
        setup(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
        run_stream(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6", "R9", 26, 1'b0);
    endtask

    task automatic t_cfg_masks_pins();  // R10: register fields zero, pins set
        setup(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0, 1'b1);
        run_stream(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R10", "R10", 20, 1'b0);
    endtask

    task automatic t_pins_frozen();     // R11: mode pins flip mid-run
        setup(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
        run_stream(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R11", "R11", 30, 1'b1);
    endtask

    initial begin
        t_indep_full();
        t_indep_split();
        t_cfg_qsel();
        t_dual_full();
        t_dual_split();
        t_cfg_masks_pins();
        t_pins_frozen();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule